// File: doc/BRIEF.md
# Four-Bank Row-Cache Hit/Miss Controller

This block sits in front of a DRAM that is split into four internal banks. It keeps one copy of a full DRAM row per bank in on-chip storage, together with a tag naming the row that was last read from that bank. A requester presents an 11-bit row, a 9-bit column, a read/write flag and 36-bit write data. The block picks the bank from two row bits that are not next to each other. It compares the other nine row bits with that bank's tag and answers with a one-cycle acknowledge.

A read that matches the tag is served from the cached row, and the DRAM side is not touched. A read that misses raises a fetch request to the DRAM side. That side streams the whole row into the bank's copy, and the block then reloads the tag. Every write is forwarded to the DRAM-side write port. When the write matches the cached row of its bank, the cached word is patched as well. A write to any other row leaves all cached rows and tags as they were.

Top module: `rowcache_ctrl`

## Requirements
- R1: The bank index is {row[2], row[9]}, with row[2] as the more significant bit: (0,0) selects bank 0, (0,1) bank 1, (1,0) bank 2 and (1,1) bank 3. `fetch_bank` and `wr_bank` carry this index.
- R2: The tag of a row is its other nine bits {row[10], row[8:3], row[1:0]}. A request hits only when its bank holds a valid entry whose tag equals the request's tag.
- R3: After reset, `rsp_ack`, `fetch_req` and `wr_valid` are low and every bank entry is invalid, so the first read to each bank misses.
- R4: A read hit is acknowledged on the clock edge after the edge that accepts it. The read returns the cached word at the requested column, with `rsp_hit` high, and `fetch_req` is not raised.
- R5: A read miss raises `fetch_req` with the bank and full row, and holds it until `fill_done`. The words arriving with `fill_valid` are stored in column order starting at 0. The acknowledge follows the `fill_done` edge, returns the streamed word at the requested column, and has `rsp_hit` low.
- R6: A bank's tag is reloaded only on a read miss. After a read miss the same row hits, and the row it replaced misses.
- R7: Every write, hit or miss, raises `wr_valid` with bank, row, column and data, held stable until `wr_ready`. The acknowledge follows the edge on which `wr_ready` is high.
- R8: A write hit also replaces the cached word, so a later read of that column returns the new data.
- R9: A write miss changes no cached word and no tag, and raises no fetch. The rows cached before it still hit with their old data, and the written row still misses on a read.
- R10: Each bank's cached row and tag are independent. A miss in one bank leaves the rows cached in the other banks able to hit with unchanged data.
- R11: `rsp_hit` reports whether the acknowledged request, read or write, hit the cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; held until `rsp_ack` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | 11 | Row address |
| req_col | input | 9 | Column address |
| req_wdata | input | 36 | Write data |
| rsp_ack | output | 1 | One-cycle request completion |
| rsp_hit | output | 1 | Completed request hit the cache |
| rsp_rdata | output | 36 | Read data, valid with `rsp_ack` on reads |
| fetch_req | output | 1 | Row fetch request to the DRAM side |
| fetch_bank | output | 2 | Bank of the fetch |
| fetch_row | output | 11 | Row of the fetch |
| fill_valid | input | 1 | Streamed row word valid |
| fill_data | input | 36 | Streamed row word |
| fill_done | input | 1 | Row stream finished |
| wr_valid | output | 1 | Write forwarded to the DRAM side |
| wr_bank | output | 2 | Bank of the write |
| wr_row | output | 11 | Row of the write |
| wr_col | output | 9 | Column of the write |
| wr_data | output | 36 | Data of the write |
| wr_ready | input | 1 | DRAM side accepts the write |

## Verification
A wrong tag or valid bit shows at the ports on the very next request to that bank. A false hit returns without a fetch, one cycle after acceptance, and carries stale data. A false miss raises `fetch_req` where none was due. A corrupted cached word only shows when its column is read again. For that reason the bench sweeps every column of every cached row after each fill, write hit and write miss, and replays a long mixed sequence against an arithmetic model of tags and row contents. Wrong stream ordering appears as data that differs from the column-indexed pattern the DRAM model sends.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WRITE = 2'd2
    } rcc_state_e;

    localparam int NBANK  = 4;
    localparam int BANK_W = 2;
endpackage

// File: rtl/rcc_addr_split.sv
module rcc_addr_split #(
    parameter int ROW_W    = 11,
    parameter int BSEL_MSB = 2,
    parameter int BSEL_LSB = 9,
    localparam int TAG_W   = ROW_W - 2
) (
    input  logic [ROW_W-1:0] row,
    output logic [1:0]       bank,
    output logic [TAG_W-1:0] tag
);
    always_comb begin
        int k;
        k    = 0;
        tag  = '0;
        bank = {row[BSEL_MSB], row[BSEL_LSB]};
        for (int i = 0; i < ROW_W; i++) begin
            if (i != BSEL_MSB && i != BSEL_LSB) begin
                tag[k] = row[i];
                k      = k + 1;
            end
        end
    end
endmodule

// File: rtl/rcc_tag_store.sv
module rcc_tag_store #(
    parameter int TAG_W = 9,
    parameter int NBANK = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(NBANK)-1:0] lk_bank,
    input  logic [TAG_W-1:0]         lk_tag,
    output logic                     lk_hit,
    input  logic                     ld_en,
    input  logic [$clog2(NBANK)-1:0] ld_bank,
    input  logic [TAG_W-1:0]         ld_tag
);
    logic [TAG_W-1:0] tag_d [NBANK];
    logic [TAG_W-1:0] tag_q [NBANK];
    logic [NBANK-1:0] vld_d, vld_q;

    always_comb begin
        tag_d = tag_q;
        vld_d = vld_q;
        if (ld_en) begin
            tag_d[ld_bank] = ld_tag;
            vld_d[ld_bank] = 1'b1;
        end
        lk_hit = vld_q[lk_bank] && (tag_q[lk_bank] == lk_tag);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int b = 0; b < NBANK; b++) tag_q[b] <= '0;
        end else begin
            vld_q <= vld_d;
            tag_q <= tag_d;
        end
    end

    // R6: a load leaves the entry valid and holding the loaded tag
    assert_load_sets_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (vld_q[$past(ld_bank)] && tag_q[$past(ld_bank)] == $past(ld_tag)));
endmodule

// File: rtl/rcc_row_store.sv
module rcc_row_store #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 36,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/rowcache_ctrl.sv
module rowcache_ctrl
    import rcc_pkg::*;
#(
    parameter int ROW_W    = 11,
    parameter int COL_W    = 9,
    parameter int DATA_W   = 36,
    parameter int BSEL_MSB = 2,
    parameter int BSEL_LSB = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_ack,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              fetch_req,
    output logic [1:0]        fetch_bank,
    output logic [ROW_W-1:0]  fetch_row,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              fill_done,
    output logic              wr_valid,
    output logic [1:0]        wr_bank,
    output logic [ROW_W-1:0]  wr_row,
    output logic [COL_W-1:0]  wr_col,
    output logic [DATA_W-1:0] wr_data,
    input  logic              wr_ready
);
    localparam int TAG_W  = ROW_W - 2;
    localparam int ADDR_W = BANK_W + COL_W;

    typedef struct packed {
        rcc_state_e        st;
        logic              ack;
        logic              hit;
        logic [DATA_W-1:0] rdata;
        logic [1:0]        bank;
        logic [TAG_W-1:0]  tag;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [DATA_W-1:0] wdata;
        logic              fetch;
        logic              wr;
        logic [COL_W-1:0]  cnt;
    } ctrl_t;

    ctrl_t d, q;

    logic [1:0]        lk_bank;
    logic [TAG_W-1:0]  lk_tag;
    logic              lk_hit;
    logic              ld_en;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;

    rcc_addr_split #(.ROW_W(ROW_W), .BSEL_MSB(BSEL_MSB), .BSEL_LSB(BSEL_LSB)) u_split (
        .row (req_row),
        .bank(lk_bank),
        .tag (lk_tag)
    );

    rcc_tag_store #(.TAG_W(TAG_W), .NBANK(NBANK)) u_tags (
        .clk    (clk),
        .rst_n  (rst_n),
        .lk_bank(lk_bank),
        .lk_tag (lk_tag),
        .lk_hit (lk_hit),
        .ld_en  (ld_en),
        .ld_bank(q.bank),
        .ld_tag (q.tag)
    );

    rcc_row_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rows (
        .clk  (clk),
        .we   (mem_we),
        .waddr(mem_waddr),
        .wdata(mem_wdata),
        .raddr({lk_bank, req_col}),
        .rdata(mem_rdata)
    );

    always_comb begin
        d         = q;
        d.ack     = 1'b0;
        ld_en     = 1'b0;
        mem_we    = 1'b0;
        mem_waddr = {q.bank, q.cnt};
        mem_wdata = fill_data;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid && !q.ack) begin
                    d.bank  = lk_bank;
                    d.tag   = lk_tag;
                    d.row   = req_row;
                    d.col   = req_col;
                    d.wdata = req_wdata;
                    d.hit   = lk_hit;
                    if (req_write) begin
                        d.st = ST_WRITE;
                        d.wr = 1'b1;
                        if (lk_hit) begin
                            mem_we    = 1'b1;
                            mem_waddr = {lk_bank, req_col};
                            mem_wdata = req_wdata;
                        end
                    end else if (lk_hit) begin
                        d.ack   = 1'b1;
                        d.rdata = mem_rdata;
                    end else begin
                        d.st    = ST_FETCH;
                        d.fetch = 1'b1;
                        d.cnt   = '0;
                    end
                end
            end
            ST_FETCH: begin
                if (fill_valid) begin
                    mem_we = 1'b1;
                    if (q.cnt == q.col) d.rdata = fill_data;
                    d.cnt = q.cnt + 1'b1;
                end
                if (fill_done) begin
                    ld_en   = 1'b1;
                    d.fetch = 1'b0;
                    d.ack   = 1'b1;
                    d.st    = ST_IDLE;
                end
            end
            ST_WRITE: begin
                if (wr_ready) begin
                    d.wr  = 1'b0;
                    d.ack = 1'b1;
                    d.st  = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign rsp_ack    = q.ack;
    assign rsp_hit    = q.hit;
    assign rsp_rdata  = q.rdata;
    assign fetch_req  = q.fetch;
    assign fetch_bank = q.bank;
    assign fetch_row  = q.row;
    assign wr_valid   = q.wr;
    assign wr_bank    = q.bank;
    assign wr_row     = q.row;
    assign wr_col     = q.col;
    assign wr_data    = q.wdata;

    // R4: the acknowledge lasts a single cycle
    assert_ack_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ack |=> !rsp_ack);
    // R4: a fetch never starts from a lookup that hit
    assert_no_fetch_on_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fetch_req) |-> !$past(lk_hit));
    // R5: the fetch request and its row stay put until the stream ends
    assert_fetch_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fill_done) |=> (fetch_req && $stable(fetch_row) && $stable(fetch_bank)));
    // R7: a forwarded write stays stable until accepted
    assert_write_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_col) && $stable(wr_row)));
    // R9: no tag is reloaded while a write is in flight
    assert_write_no_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !ld_en);
    // R5: fetch and write never overlap
    assert_single_side_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_req && wr_valid));
endmodule

// File: tb/rowcache_ctrl_tb.sv
module rowcache_ctrl_tb;
    localparam int ROW_W  = 11;
    localparam int COL_W  = 5;
    localparam int DATA_W = 36;
    localparam int NCOL   = 1 << COL_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0, req_write = 1'b0;
    logic [ROW_W-1:0]  req_row = '0;
    logic [COL_W-1:0]  req_col = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rsp_ack, rsp_hit;
    logic [DATA_W-1:0] rsp_rdata;
    logic              fetch_req;
    logic [1:0]        fetch_bank;
    logic [ROW_W-1:0]  fetch_row;
    logic              fill_valid = 1'b0, fill_done = 1'b0;
    logic [DATA_W-1:0] fill_data = '0;
    logic              wr_valid;
    logic [1:0]        wr_bank;
    logic [ROW_W-1:0]  wr_row;
    logic [COL_W-1:0]  wr_col;
    logic [DATA_W-1:0] wr_data;
    logic              wr_ready = 1'b0;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    logic [8:0]        m_tag [4];
    logic              m_vld [4];
    logic [DATA_W-1:0] m_row [4][NCOL];

    always #5 clk = ~clk;

    rowcache_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_row(req_row),
        .req_col(req_col), .req_wdata(req_wdata),
        .rsp_ack(rsp_ack), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
        .fetch_req(fetch_req), .fetch_bank(fetch_bank), .fetch_row(fetch_row),
        .fill_valid(fill_valid), .fill_data(fill_data), .fill_done(fill_done),
        .wr_valid(wr_valid), .wr_bank(wr_bank), .wr_row(wr_row), .wr_col(wr_col),
        .wr_data(wr_data), .wr_ready(wr_ready)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog: actual cycles %0d expected below 150000", cycles);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] bank_of(input logic [ROW_W-1:0] r);
        return {r[2], r[9]};
    endfunction

    function automatic logic [8:0] tag_of(input logic [ROW_W-1:0] r);
        return {r[10], r[8:3], r[1:0]};
    endfunction

    function automatic logic [DATA_W-1:0] dram_word(input logic [ROW_W-1:0] r, input int c);
        logic [15:0] mix;
        mix = 16'(int'(r) * 7 + c * 3 + 5);
        return {r, 9'(c), mix};
    endfunction

    // One request with DRAM-side models; checks against the arithmetic model.
    task automatic do_op(input bit wr, input logic [ROW_W-1:0] r, input int c,
                         input logic [DATA_W-1:0] wd);
        logic [1:0] b;
        bit exp_hit, fetched, wrote, held_ok;
        int fill_i, wcnt, cyc;
        logic [1:0] fb, wb;
        logic [ROW_W-1:0] fr, wrr;
        logic [COL_W-1:0] wc;
        logic [DATA_W-1:0] wdat, got;
        b = bank_of(r);
        exp_hit = m_vld[b] && (m_tag[b] == tag_of(r));
        fetched = 0; wrote = 0; held_ok = 1; fill_i = 0; wcnt = 0; cyc = 0;
        fb = '0; fr = '0; wb = '0; wrr = '0; wc = '0; wdat = '0; got = '0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_row = r; req_col = COL_W'(c); req_wdata = wd;
        forever begin
            @(negedge clk);
            cyc++;
            fill_valid = 1'b0; fill_done = 1'b0; wr_ready = 1'b0;
            if (rsp_ack) begin
                got = rsp_rdata;
                req_valid = 1'b0;
                break;
            end
            if (cyc > 300) begin
                chk(0, "R5/R7 handshake timeout", 64'(cyc), 64'd300);
                req_valid = 1'b0;
                break;
            end
            if (fetch_req && fill_i <= NCOL) begin
                if (fill_i == 0) begin fetched = 1; fb = fetch_bank; fr = fetch_row; end
                if (fill_i < NCOL) begin
                    fill_valid = 1'b1;
                    fill_data  = dram_word(fetch_row, fill_i);
                end else begin
                    fill_done = 1'b1;
                end
                fill_i++;
            end
            if (wr_valid && !wrote) begin
                if (wcnt == 0) begin wb = wr_bank; wrr = wr_row; wc = wr_col; wdat = wr_data; end
                else if (wr_data != wdat || wr_col != wc) held_ok = 0;
                if (wcnt == 2) begin wr_ready = 1'b1; wrote = 1; end
                wcnt++;
            end
        end
        chk(rsp_hit == exp_hit, "R2/R11 hit flag", 64'(rsp_hit), 64'(exp_hit));
        if (!wr) begin
            chk(fetched == !exp_hit, "R4/R5 fetch only on miss", 64'(fetched), 64'(!exp_hit));
            if (exp_hit) begin
                chk(got == m_row[b][c], "R4 hit data", got, m_row[b][c]);
                chk(cyc == 1, "R4 hit latency", 64'(cyc), 64'd1);
            end else begin
                chk(fb == b, "R1 fetch bank", 64'(fb), 64'(b));
                chk(fr == r, "R5 fetch row", 64'(fr), 64'(r));
                chk(got == dram_word(r, c), "R5 miss data", got, dram_word(r, c));
                m_vld[b] = 1'b1;
                m_tag[b] = tag_of(r);
                for (int i = 0; i < NCOL; i++) m_row[b][i] = dram_word(r, i);
            end
        end else begin
            chk(!fetched, "R9 no fetch on write", 64'(fetched), 64'd0);
            chk(wrote && wb == b, "R1 write bank", 64'(wb), 64'(b));
            chk(wrr == r && wc == COL_W'(c), "R7 write row/col", {wrr, wc}, {r, COL_W'(c)});
            chk(wdat == wd && held_ok, "R7 write data held", wdat, wd);
            chk(cyc == 4, "R7 ack after accept", 64'(cyc), 64'd4);
            if (exp_hit) m_row[b][c] = wd;
        end
    endtask

    task automatic sweep_row(input logic [ROW_W-1:0] r);
        for (int c = 0; c < NCOL; c++) do_op(1'b0, r, c, '0);
    endtask

    initial begin
        logic [15:0] lfsr;
        logic [ROW_W-1:0] pool [8];
        for (int b = 0; b < 4; b++) begin m_vld[b] = 1'b0; m_tag[b] = '0; end
        pool = '{11'h000, 11'h200, 11'h004, 11'h204, 11'h008, 11'h3F8, 11'h6A1, 11'h7FF};
        repeat (3) @(negedge clk);
        // R3: reset state
        chk(!rsp_ack && !fetch_req && !wr_valid, "R3 idle outputs after reset",
            {rsp_ack, fetch_req, wr_valid}, 64'd0);
        rst_n = 1'b1;
        // R1/R3/R5: first read per bank misses; rows differ only in bank bits
        do_op(1'b0, 11'h000, 3, '0);
        do_op(1'b0, 11'h200, 5, '0);
        do_op(1'b0, 11'h004, 7, '0);
        do_op(1'b0, 11'h204, 31, '0);
        // R4/R10: every column of every bank hits
        sweep_row(11'h000); sweep_row(11'h200); sweep_row(11'h004); sweep_row(11'h204);
        // R8: write hits patch cached words
        do_op(1'b1, 11'h200, 7, 36'hABCDE1234);
        do_op(1'b1, 11'h200, 0, 36'h111111111);
        do_op(1'b1, 11'h200, 31, 36'hFFFFFFFFF);
        sweep_row(11'h200);
        // R9: write miss in bank 3 leaves row and tag alone
        do_op(1'b1, 11'h20C, 4, 36'h0DEADBEEF);
        sweep_row(11'h204);
        do_op(1'b0, 11'h20C, 4, '0);
        // R6/R10: bank 0 replaced; other banks keep their rows
        do_op(1'b0, 11'h0F8, 9, '0);
        sweep_row(11'h200); sweep_row(11'h004); sweep_row(11'h20C);
        do_op(1'b0, 11'h0F8, 2, '0);
        do_op(1'b0, 11'h000, 3, '0);
        // mixed sequence over a small row pool
        lfsr = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            do_op(lfsr[0] & lfsr[5], pool[lfsr[3:1]], int'(lfsr[10:6]),
                  {lfsr, lfsr, lfsr[3:0]});
        end
        summary();
        $finish;
    end
endmodule